// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of one-bit lock tokens shared by two processor ports, called left and right, in a single clock domain. Each token can stand for one shared region or resource. A port asks for a token by writing a zero to that token's slot. It then reads the slot back. A read of zero means the port now holds the token. A read of one means it does not. Writing a one to the slot gives the token up, or cancels a request that has not been granted.

Each port keeps its own request flop for every token. An owner register per token records which side, if any, holds it. A request that loses stays latched. It takes the token as soon as the holder lets go, unless its port has withdrawn it first. When both sides ask for a free token on the same clock edge, the left port wins. Reset marks every request flag as free, so software starts with no token taken.

Top module: `twin_port_token_bank`

## Requirements
- R1: There are eight tokens, selected by a 3-bit slot index; an action on one token never changes the state of another, and the two ports may hold different tokens at the same time.
- R2: A write with data 0 to a free token grants it to the writing port; from the cycle after the write edge, that port reads 0 at the slot and the other port reads 1.
- R3: For any token, the two ports never both read 0 in the same cycle.
- R4: A write with data 1 from the holder releases the token; from the next cycle the holder reads 1 at that slot.
- R5: When one port already holds a token, a later request from the other port does not take it away; the later port reads 1 while its request is pending.
- R6: When both ports write 0 to the same free token on the same edge, the left port receives it and the right port's request stays pending.
- R7: A pending request is granted on the same edge where the holder writes 1, so the waiting port reads 0 from the following cycle.
- R8: A port that writes 1 while its request is pending withdraws the request; it is not granted when the holder later releases, and the token becomes free.
- R9: After reset, every token is free and both ports read 1 at every slot.
- R10: With the write enable low, a port's address and data have no effect on any token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rstN | input | 1 | Active-low synchronous reset, frees every token |
| lAddr | input | 3 | Left port token slot for read and write |
| lWe | input | 1 | Left port write enable |
| lWdata | input | 1 | Left port write data: 0 requests, 1 releases |
| lRdata | output | 1 | Left port readback: 0 when left holds the addressed token |
| rAddr | input | 3 | Right port token slot for read and write |
| rWe | input | 1 | Right port write enable |
| rWdata | input | 1 | Right port write data: 0 requests, 1 releases |
| rRdata | output | 1 | Right port readback: 0 when right holds the addressed token |

## Verification
Two things can fall on the same edge. The first is both ports requesting one free token. The second is one port releasing a token while the other's request for it is pending. The bench produces the first with a directed same-edge write to one slot. It produces the second with a holder release while a loser waits. A long random run then keeps both ports inside a two-slot window, so that claims, releases and withdrawals collide often. After every edge the bench reads all eight slots from both ports. It compares them with a model built from the grant rules: tie to the left, a holder keeps its token while it still requests, a pending request is granted on release. It also flags any slot where both ports read zero.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int unsigned TOKEN_IDX_W = 3;
  localparam int unsigned TOKEN_COUNT = 1 << TOKEN_IDX_W;

  // per-port strobe bundle handed from decode to the token core
  typedef struct packed {
    logic                   claim;
    logic                   drop;
    logic [TOKEN_IDX_W-1:0] slot;
  } portCmd_t;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/tpt_cmd_decode.sv
module tpt_cmd_decode
  import tpt_pkg::*;
(
  input  logic                   lWe,
  input  logic [TOKEN_IDX_W-1:0] lAddr,
  input  logic                   lWdata,
  input  logic                   rWe,
  input  logic [TOKEN_IDX_W-1:0] rAddr,
  input  logic                   rWdata,
  output portCmd_t               lCmd,
  output portCmd_t               rCmd
);
  // a write of 0 is a claim, a write of 1 is a drop; no write, no strobe
  always_comb begin
    lCmd.claim = lWe & ~lWdata;
    lCmd.drop  = lWe &  lWdata;
    lCmd.slot  = lAddr;
    rCmd.claim = rWe & ~rWdata;
    rCmd.drop  = rWe &  rWdata;
    rCmd.slot  = rAddr;
  end
endmodule

// File: rtl/tpt_token_core.sv
module tpt_token_core
  import tpt_pkg::*;
#(
  parameter int unsigned NUM_TOKENS = TOKEN_COUNT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  portCmd_t               lCmd,
  input  portCmd_t               rCmd,
  input  logic [TOKEN_IDX_W-1:0] lAddr,
  input  logic [TOKEN_IDX_W-1:0] rAddr,
  output logic                   lRdata,
  output logic                   rRdata,
  output logic [NUM_TOKENS-1:0]  reqL,
  output logic [NUM_TOKENS-1:0]  reqR,
  output logic [NUM_TOKENS-1:0]  ownL,
  output logic [NUM_TOKENS-1:0]  ownR
);
  owner_e ownerQ [NUM_TOKENS];

  for (genvar i = 0; i < NUM_TOKENS; i++) begin : g_token
    logic   reqLNext;
    logic   reqRNext;
    owner_e ownerNext;

    // request flops per side, updated from that side's strobes only
    always_comb begin
      reqLNext = reqL[i];
      if (lCmd.slot == TOKEN_IDX_W'(i)) begin
        if (lCmd.claim) reqLNext = 1'b1;
        if (lCmd.drop)  reqLNext = 1'b0;
      end
      reqRNext = reqR[i];
      if (rCmd.slot == TOKEN_IDX_W'(i)) begin
        if (rCmd.claim) reqRNext = 1'b1;
        if (rCmd.drop)  reqRNext = 1'b0;
      end
    end

    // holder keeps while requesting; otherwise left first, then right
    always_comb begin
      if (ownerQ[i] == OWN_LEFT && reqLNext)        ownerNext = OWN_LEFT;
      else if (ownerQ[i] == OWN_RIGHT && reqRNext)  ownerNext = OWN_RIGHT;
      else if (reqLNext)                            ownerNext = OWN_LEFT;
      else if (reqRNext)                            ownerNext = OWN_RIGHT;
      else                                          ownerNext = OWN_NONE;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqL[i]   <= 1'b0;
        reqR[i]   <= 1'b0;
        ownerQ[i] <= OWN_NONE;
      end else begin
        reqL[i]   <= reqLNext;
        reqR[i]   <= reqRNext;
        ownerQ[i] <= ownerNext;
      end
    end

    assign ownL[i] = (ownerQ[i] == OWN_LEFT);
    assign ownR[i] = (ownerQ[i] == OWN_RIGHT);
  end

  // readback: 0 means the reading side holds the addressed token
  assign lRdata = ~ownL[lAddr];
  assign rRdata = ~ownR[rAddr];
endmodule

// File: rtl/twin_port_token_bank.sv
module twin_port_token_bank
  import tpt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TOKEN_IDX_W-1:0] lAddr,
  input  logic                   lWe,
  input  logic                   lWdata,
  output logic                   lRdata,
  input  logic [TOKEN_IDX_W-1:0] rAddr,
  input  logic                   rWe,
  input  logic                   rWdata,
  output logic                   rRdata
);
  portCmd_t                 lCmd;
  portCmd_t                 rCmd;
  logic [TOKEN_COUNT-1:0]   reqLVec;
  logic [TOKEN_COUNT-1:0]   reqRVec;
  logic [TOKEN_COUNT-1:0]   ownLVec;
  logic [TOKEN_COUNT-1:0]   ownRVec;

  tpt_cmd_decode u_decode (
    .lWe    (lWe),
    .lAddr  (lAddr),
    .lWdata (lWdata),
    .rWe    (rWe),
    .rAddr  (rAddr),
    .rWdata (rWdata),
    .lCmd   (lCmd),
    .rCmd   (rCmd)
  );

  tpt_token_core #(.NUM_TOKENS(TOKEN_COUNT)) u_core (
    .clk    (clk),
    .rstN   (rstN),
    .lCmd   (lCmd),
    .rCmd   (rCmd),
    .lAddr  (lAddr),
    .rAddr  (rAddr),
    .lRdata (lRdata),
    .rRdata (rRdata),
    .reqL   (reqLVec),
    .reqR   (reqRVec),
    .ownL   (ownLVec),
    .ownR   (ownRVec)
  );
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker
  import tpt_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [TOKEN_IDX_W-1:0] lAddr,
  input logic                   lWe,
  input logic                   lWdata,
  input logic                   lRdata,
  input logic [TOKEN_IDX_W-1:0] rAddr,
  input logic                   rWe,
  input logic                   rWdata,
  input logic                   rRdata,
  input logic [TOKEN_COUNT-1:0] reqL,
  input logic [TOKEN_COUNT-1:0] reqR,
  input logic [TOKEN_COUNT-1:0] ownL,
  input logic [TOKEN_COUNT-1:0] ownR
);
  a_r3_exclusive_read: assert property (@(posedge clk) disable iff (!rstN)
    (lAddr == rAddr) |-> (lRdata || rRdata));

  a_r4_left_release: assert property (@(posedge clk) disable iff (!rstN)
    (lWe && lWdata) |=> ((lAddr != $past(lAddr)) || lRdata));

  a_r4_right_release: assert property (@(posedge clk) disable iff (!rstN)
    (rWe && rWdata) |=> ((rAddr != $past(rAddr)) || rRdata));

  a_r6_left_wins_tie: assert property (@(posedge clk) disable iff (!rstN)
    (lWe && !lWdata && rWe && !rWdata && lAddr == rAddr &&
     !ownL[lAddr] && !ownR[lAddr]) |=> ownL[$past(lAddr)]);

  a_r7_no_idle_request: assert property (@(posedge clk) disable iff (!rstN)
    (((reqL | reqR) & ~(ownL | ownR)) == '0));

  a_r2_holder_has_request: assert property (@(posedge clk) disable iff (!rstN)
    (((ownL & ~reqL) | (ownR & ~reqR)) == '0));

  a_r5_holder_kept: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(ownL) & reqL & ~ownL) | ($past(ownR) & reqR & ~ownR)) == '0));
endmodule

bind twin_port_token_bank tpt_checker u_tpt_checker (
  .clk    (clk),
  .rstN   (rstN),
  .lAddr  (lAddr),
  .lWe    (lWe),
  .lWdata (lWdata),
  .lRdata (lRdata),
  .rAddr  (rAddr),
  .rWe    (rWe),
  .rWdata (rWdata),
  .rRdata (rRdata),
  .reqL   (reqLVec),
  .reqR   (reqRVec),
  .ownL   (ownLVec),
  .ownR   (ownRVec)
);

// File: tb/test_twin_port_token_bank.sv
module test_twin_port_token_bank;
  localparam int CLK_PERIOD = 20;
  localparam int NTOK = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] lAddr = '0;
  logic       lWe = 1'b0;
  logic       lWdata = 1'b1;
  logic       lRdata;
  logic [2:0] rAddr = '0;
  logic       rWe = 1'b0;
  logic       rWdata = 1'b1;
  logic       rRdata;

  int nCmp = 0;
  int nBad = 0;

  // model: request flags and owner (0 none, 1 left, 2 right)
  bit mReqL [NTOK];
  bit mReqR [NTOK];
  int mOwn  [NTOK];

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_port_token_bank i_twin_port_token_bank (
    .clk(clk), .rstN(rstN),
    .lAddr(lAddr), .lWe(lWe), .lWdata(lWdata), .lRdata(lRdata),
    .rAddr(rAddr), .rWe(rWe), .rWdata(rWdata), .rRdata(rRdata)
  );

  task automatic modelClear();
    for (int i = 0; i < NTOK; i++) begin
      mReqL[i] = 1'b0; mReqR[i] = 1'b0; mOwn[i] = 0;
    end
  endtask

  task automatic modelStep(input bit lw, input int la, input bit ld,
                           input bit rw, input int ra, input bit rd);
    for (int i = 0; i < NTOK; i++) begin
      if (lw && la == i) mReqL[i] = !ld;
      if (rw && ra == i) mReqR[i] = !rd;
      if (mOwn[i] == 1 && mReqL[i])      mOwn[i] = 1;
      else if (mOwn[i] == 2 && mReqR[i]) mOwn[i] = 2;
      else if (mReqL[i])                 mOwn[i] = 1;
      else if (mReqR[i])                 mOwn[i] = 2;
      else                               mOwn[i] = 0;
    end
  endtask

  // inputs set away from the edge, model advanced at the edge
  task automatic drive(input bit lw, input int la, input bit ld,
                       input bit rw, input int ra, input bit rd);
    lWe = lw; lAddr = 3'(la); lWdata = ld;
    rWe = rw; rAddr = 3'(ra); rWdata = rd;
    @(posedge clk);
    modelStep(lw, la, ld, rw, ra, rd);
    #1;
    lWe = 1'b0; rWe = 1'b0;
  endtask

  task automatic scan(input string tag);
    for (int a = 0; a < NTOK; a++) begin
      lAddr = 3'(a); rAddr = 3'(a);
      #1;
      nCmp++;
      if (lRdata !== (mOwn[a] != 1)) begin
        nBad++;
        $display("FAIL %s left slot %0d: got %b expected %b", tag, a, lRdata, (mOwn[a] != 1));
      end
      nCmp++;
      if (rRdata !== (mOwn[a] != 2)) begin
        nBad++;
        $display("FAIL %s right slot %0d: got %b expected %b", tag, a, rRdata, (mOwn[a] != 2));
      end
      nCmp++;
      if (lRdata === 1'b0 && rRdata === 1'b0) begin
        nBad++;
        $display("FAIL R3 slot %0d: both read 0, got %b%b expected not 00", a, lRdata, rRdata);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    scan("R9 reset all free");

    drive(1, 2, 0, 0, 0, 0);       scan("R2 left claims free slot 2");
    drive(0, 0, 0, 1, 2, 0);       scan("R5 right later request waits");
    drive(1, 2, 1, 0, 0, 0);       scan("R7 pending right granted on release");
    drive(0, 0, 0, 1, 2, 1);       scan("R4 right release frees slot 2");
    drive(1, 5, 0, 1, 5, 0);       scan("R6 same-edge tie goes left");
    drive(0, 0, 0, 1, 5, 1);       scan("R8 right withdraws pending");
    drive(1, 5, 1, 0, 0, 0);       scan("R8 release after withdraw leaves free");
    drive(1, 0, 0, 1, 1, 0);       scan("R1 distinct slots held at once");
    drive(0, 0, 1, 0, 1, 1);       scan("R10 address and data ignored without enable");
    drive(0, 0, 0, 0, 1, 0);       scan("R10 claim data ignored without enable");
    drive(1, 0, 1, 1, 1, 1);       scan("R4 both release");

    // near-exhaustive: every action pair on a shared slot, from every start state
    for (int s = 0; s < 9; s++) begin
      for (int p = 0; p < 9; p++) begin
        drive(s % 3 != 0, 3, s % 3 == 2, s / 3 != 0, 3, s / 3 == 2);
        drive(p % 3 != 0, 3, p % 3 == 2, p / 3 != 0, 3, p / 3 == 2);
        scan("R7 action pair sweep");
        drive(1, 3, 1, 1, 3, 1);
      end
    end

    // random contention within a two-slot window, with occasional wide addresses
    for (int n = 0; n < 3000; n++) begin
      int la = ($urandom % 8 == 0) ? int'($urandom % NTOK) : int'($urandom % 2);
      int ra = ($urandom % 8 == 0) ? int'($urandom % NTOK) : int'($urandom % 2);
      drive($urandom % 2, la, $urandom % 2, $urandom % 2, ra, $urandom % 2);
      scan("R3 random contention");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule